// File: doc/BRIEF.md
# Eight-Channel Input Capture Edge Unit

This block is the input capture front end of a 16-bit timer. Each of its eight channels watches one external pin and passes it through a two-flop synchroniser. A per-channel two-bit mode picks which transitions count: none, rising, falling or both. On a transition that counts, the channel stores the current value of the free-running timer counter in its capture register and raises its status flag.

A per-channel enable mask gates the flags onto one combined interrupt request. Software reaches the edge modes, the enable mask, the flags and the capture registers through a simple single-cycle register bus. Writes take effect at the clock edge. Read data follows the address combinationally.

Top module: `icap_unit`

## Requirements
- R1: The edge-mode register at address 0 holds a two-bit field per channel, channel n at bits [2n+1:2n]. It is read and written whole.
- R2: A channel whose mode field is 00 never captures and never sets its flag.
- R3: Mode 01 captures only on a low-to-high pin transition. Mode 10 captures only on a high-to-low transition.
- R4: Mode 11 captures on every transition in either direction.
- R5: Suppose a pin transition that counts is first sampled at clock edge k. The counter value present before edge k+2 is then stored in the capture register of that channel, at address 8+n. At the same edge k+2 the flag for the channel is set.
- R6: The flag register sits at address 2, with channel n at bit n. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. A capture in the same cycle as a clear of the same bit leaves the flag set.
- R7: The enable mask sits at address 1, with channel n at bit n. It is read and written at any time.
- R8: The following have no effect: writes to bits [15:8] of addresses 1 and 2, writes to the capture registers, and writes to unmapped addresses. Those upper bits read as zero, and unmapped addresses read as zero.
- R9: The interrupt output is high exactly when some channel has both its flag and its enable bit set.
- R10: After reset, every register reads zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntVal | input | 16 | Free-running timer counter value |
| pinIn | input | 8 | Asynchronous capture pins, one per channel |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write when high, together with busSel |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irqOut | output | 1 | Combined capture interrupt request |

## Verification
A pin transition first sampled at edge k shows up in the flag register, the capture register and the interrupt only after edge k+2. A register write is visible right after the edge that takes it. Read data and the interrupt follow combinationally within the same cycle. The bench drives inputs just after the falling edge and updates its reference model at each rising edge. It compares both outputs at every falling edge, so every result is checked in the first cycle it is due. The same-cycle clear-versus-capture case is timed so that the clear write lands exactly on edge k+2.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAP0 = 4'd8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edgeMode_e;

  typedef struct packed {
    logic              wrMode;
    logic              wrMask;
    logic              wrClr;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/icap_datapath.sv
module icap_datapath
  import icap_pkg::*;
#(
  parameter int NUM_CH = icap_pkg::NUM_CH,
  parameter int CNT_W  = icap_pkg::CNT_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [NUM_CH-1:0]             pinSync,
  input  logic [CNT_W-1:0]              cntVal,
  output logic [2*NUM_CH-1:0]           modeReg,
  output logic [NUM_CH-1:0]             enMask,
  output logic [NUM_CH-1:0]             flags,
  output logic [NUM_CH-1:0][CNT_W-1:0]  capArr,
  output logic                          irqOut
);
  logic [NUM_CH-1:0] pinPrev;
  logic [NUM_CH-1:0] riseDet;
  logic [NUM_CH-1:0] fallDet;
  logic [NUM_CH-1:0] capHit;
  logic [NUM_CH-1:0] clrMask;

  assign riseDet = pinSync & ~pinPrev;
  assign fallDet = ~pinSync & pinPrev;
  assign clrMask = stb.wrClr ? stb.wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    edgeMode_e chMode;
    assign chMode = edgeMode_e'(modeReg[2*ch +: 2]);

    always_comb begin
      unique case (chMode)
        EDGE_RISE: capHit[ch] = riseDet[ch];
        EDGE_FALL: capHit[ch] = fallDet[ch];
        EDGE_ANY:  capHit[ch] = riseDet[ch] | fallDet[ch];
        default:   capHit[ch] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            capArr[ch] <= '0;
      else if (capHit[ch])  capArr[ch] <= cntVal;
    end

    // R5: the stored value is the counter seen at the capture edge
    p_cap_value_r5: assert property (@(posedge clk) disable iff (!rstN)
      capHit[ch] |=> capArr[ch] == $past(cntVal));

    // R2: a disabled channel never captures
    p_off_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
      (chMode == EDGE_OFF) |-> !capHit[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      enMask  <= '0;
      flags   <= '0;
    end else begin
      if (stb.wrMode) modeReg <= stb.wdata[2*NUM_CH-1:0];
      if (stb.wrMask) enMask  <= stb.wdata[NUM_CH-1:0];
      flags <= (flags & ~clrMask) | capHit;
    end
  end

  assign irqOut = |(flags & enMask);

  // R5: a capture sets its flag at that edge
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capHit != '0) |=> ((flags & $past(capHit)) == $past(capHit)));

  // R6: a clear without a simultaneous capture empties the flag
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((clrMask & ~capHit) != '0) |=> ((flags & $past(clrMask & ~capHit)) == '0));

  // R6: flags move only on capture or clear
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(capHit | clrMask)) == '0));

  // R9: no interrupt with an empty mask
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enMask != '0));
endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int NUM_CH = icap_pkg::NUM_CH,
  parameter int CNT_W  = icap_pkg::CNT_W,
  parameter int DATA_W = icap_pkg::DATA_W,
  parameter int ADDR_W = icap_pkg::ADDR_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  input  logic [2*NUM_CH-1:0]           modeReg,
  input  logic [NUM_CH-1:0]             enMask,
  input  logic [NUM_CH-1:0]             flags,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  capArr,
  output strobe_t                       stb,
  output logic [DATA_W-1:0]             busRdata
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              wrEn;
  logic [ADDR_W-1:0] capOff;
  logic              capRange;

  assign wrEn     = busSel & busWr;
  assign capOff   = busAddr - ADDR_CAP0;
  assign capRange = (busAddr >= ADDR_CAP0) && (capOff < ADDR_W'(NUM_CH));

  always_comb begin
    stb        = '0;
    stb.wdata  = busWdata;
    stb.wrMode = wrEn && (busAddr == ADDR_MODE);
    stb.wrMask = wrEn && (busAddr == ADDR_MASK);
    stb.wrClr  = wrEn && (busAddr == ADDR_FLAG);
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_MODE)      busRdata = DATA_W'(modeReg);
    else if (busAddr == ADDR_MASK) busRdata = DATA_W'(enMask);
    else if (busAddr == ADDR_FLAG) busRdata = DATA_W'(flags);
    else if (capRange)             busRdata = DATA_W'(capArr[capOff[IDX_W-1:0]]);
  end

  // R8: at most one register is written per cycle
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMode, stb.wrMask, stb.wrClr}));

  // R8: no write strobe without a bus write
  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |-> !(stb.wrMode || stb.wrMask || stb.wrClr));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int NUM_CH = icap_pkg::NUM_CH,
  parameter int CNT_W  = icap_pkg::CNT_W,
  parameter int DATA_W = icap_pkg::DATA_W,
  parameter int ADDR_W = icap_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [NUM_CH-1:0] pinIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  strobe_t                      stb;
  logic [NUM_CH-1:0]            pinSync;
  logic [2*NUM_CH-1:0]          modeReg;
  logic [NUM_CH-1:0]            enMask;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0][CNT_W-1:0] capArr;

  icap_sync #(.WIDTH(NUM_CH)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(pinSync)
  );

  icap_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .modeReg(modeReg), .enMask(enMask), .flags(flags),
    .capArr(capArr), .stb(stb), .busRdata(busRdata)
  );

  icap_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinSync(pinSync), .cntVal(cntVal),
    .modeReg(modeReg), .enMask(enMask), .flags(flags), .capArr(capArr),
    .irqOut(irqOut)
  );
endmodule

// File: tb/test_icap_unit.sv
module test_icap_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cnt = '0;
  logic [7:0]  pins = '0;
  logic        bSel = 1'b0, bWr = 1'b0;
  logic [3:0]  bAddr = '0;
  logic [15:0] bWdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  icap_unit i_icap_unit (
    .clk(clk), .rstN(rstN), .cntVal(cnt), .pinIn(pins), .busSel(bSel),
    .busWr(bWr), .busAddr(bAddr), .busWdata(bWdata), .busRdata(rdata), .irqOut(irq)
  );

  // reference model
  logic [15:0] mMode;
  logic [7:0]  mEn, mFlag, h1, h2, h3;
  logic [15:0] mCap [8];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = '0; mEn = '0; mFlag = '0; h1 = '0; h2 = '0; h3 = '0;
      for (int i = 0; i < 8; i++) mCap[i] = '0;
    end else begin
      logic [7:0] setV, clrV;
      setV = '0;
      for (int i = 0; i < 8; i++) begin
        logic r, f;
        r = h2[i] && !h3[i];
        f = !h2[i] && h3[i];
        case (mMode[2*i +: 2])
          2'b01: setV[i] = r;
          2'b10: setV[i] = f;
          2'b11: setV[i] = r || f;
          default: setV[i] = 1'b0;
        endcase
        if (setV[i]) mCap[i] = cnt;
      end
      clrV = (bSel && bWr && bAddr == 4'd2) ? bWdata[7:0] : 8'h00;
      if (bSel && bWr && bAddr == 4'd0) mMode = bWdata;
      if (bSel && bWr && bAddr == 4'd1) mEn = bWdata[7:0];
      mFlag = (mFlag & ~clrV) | setV;
      h3 = h2; h2 = h1; h1 = pins;
    end
  end

  function automatic logic [15:0] modelRead(logic [3:0] a);
    if (a == 4'd0) return mMode;
    if (a == 4'd1) return {8'h00, mEn};
    if (a == 4'd2) return {8'h00, mFlag};
    if (a >= 4'd8) return mCap[a - 4'd8];
    return 16'h0000;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      string tag;
      if (bAddr == 4'd0) tag = "R1";
      else if (bAddr == 4'd1) tag = "R7";
      else if (bAddr == 4'd2) tag = "R6";
      else if (bAddr >= 4'd8) tag = "R5";
      else tag = "R8";
      check(tag, rdata, modelRead(bAddr));
      check("R9", {15'd0, irq}, {15'd0, |(mFlag & mEn)});
    end
  end

  always @(negedge clk) #1 cnt <= cnt + 16'd3;

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic busWrite(logic [3:0] a, logic [15:0] d);
    bSel = 1'b1; bWr = 1'b1; bAddr = a; bWdata = d;
    tick();
    bSel = 1'b0; bWr = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, logic [15:0] exp, string req);
    bAddr = a; #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R10 reset state
    busRead(4'd0, 16'h0000, "R10");
    busRead(4'd1, 16'h0000, "R10");
    busRead(4'd2, 16'h0000, "R10");
    busRead(4'd9, 16'h0000, "R10");
    check("R10", {15'd0, irq}, 16'd0);

    // R1: ch0 rise, ch1 fall, ch2 any, ch3 off, ch4..7 any
    busWrite(4'd0, 16'hFF39);
    busRead(4'd0, 16'hFF39, "R1");

    pins = 8'h0F;
    repeat (3) tick();
    busRead(4'd2, 16'h0005, "R3");        // R3 rising on ch0 only, R4 ch2
    busRead(4'd8, mCap[0], "R5");
    busRead(4'd11, 16'h0000, "R2");

    pins = 8'h00;
    repeat (3) tick();
    busRead(4'd2, 16'h0007, "R4");        // R4 ch2 again, R3 falling ch1
    busRead(4'd11, 16'h0000, "R2");
    check("R2", {15'd0, mFlag[3]}, 16'd0);

    // R6 write one to clear
    busWrite(4'd2, 16'h0001);
    busRead(4'd2, 16'h0006, "R6");
    busWrite(4'd2, 16'h0000);
    busRead(4'd2, 16'h0006, "R6");
    busWrite(4'd2, 16'h0004);
    busRead(4'd2, 16'h0002, "R6");

    // R6 capture wins over clear in the same cycle
    pins = 8'h04;
    tick(); tick();
    busWrite(4'd2, 16'h0004);
    busRead(4'd2, 16'h0006, "R6");

    // R9 masking
    check("R9", {15'd0, irq}, 16'd0);
    busWrite(4'd1, 16'h0002);
    check("R9", {15'd0, irq}, 16'd1);
    busWrite(4'd1, 16'h0001);
    check("R9", {15'd0, irq}, 16'd0);

    // R7 / R8 unimplemented bits
    busWrite(4'd1, 16'hFFFF);
    busRead(4'd1, 16'h00FF, "R7");
    check("R9", {15'd0, irq}, 16'd1);
    busWrite(4'd2, 16'hFF00);
    busRead(4'd2, 16'h0006, "R8");
    bAddr = 4'd10; #1;
    keep = rdata;
    busWrite(4'd10, 16'hABCD);
    busRead(4'd10, keep, "R8");
    busWrite(4'd5, 16'h1234);
    busRead(4'd5, 16'h0000, "R8");
    busRead(4'd0, 16'hFF39, "R8");

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      pins = 8'($urandom);
      bAddr = 4'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        int s;
        s = $urandom_range(0, 3);
        busWrite(s == 3 ? 4'd8 : 4'(s), 16'($urandom));
      end else begin
        tick();
      end
    end
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule